// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves bytes between time slots of serial time-division-multiplexed links. Eight serial input streams each carry 32 byte channels per frame. Every received byte is stored in a frame-banked data memory. For each output stream and channel, a connection entry decides what goes out in that slot. The slot can carry a byte received on any input stream and channel in the previous frame, or a fixed message byte held in the connection entry. The slot can also stay silent. An external frame pulse aligns the bit counter. A drive-enable input can silence every output at once.

The block runs on the bit clock, one serial bit per clock and 256 bits per frame. Data is sent MSB first. The frame pulse is high during bit 0 of channel 0. A simple write port loads two connection memories for each output stream and channel. The route memory holds one byte per slot: source stream in bits 7:5 and source channel in bits 4:0, or the message byte itself. The control memory keeps bit 2 (message mode) and bit 0 (slot enable) of each written byte. A global message-mode input makes every slot behave as if both of those bits were set.

Top module: `tsi_switch`

## Requirements
- R1: During reset and in the first cycle after it, every `oe_o` bit and every `dout_o` bit is 0. Reset clears all control entries, so all slots stay disabled until they are configured.
- R2: For a slot with control bit 2 = 0 and bit 0 = 1, the byte received on input stream route[7:5], channel route[4:0] in frame N is sent on that output stream and channel in frame N+1. It is sent MSB first, with bit b of channel k at frame bit position 8k+b, and `oe_o` is high for all 8 bits.
- R3: For a slot with control bit 2 = 1 and bit 0 = 1, the route byte itself is sent in that slot in every frame, MSB first.
- R4: For a slot with control bit 0 = 0 (and global message mode off), `oe_o` is low and `dout_o` is 0 for the whole slot, whatever bit 2 holds.
- R5: While `msg_all_i` is 1, every slot sends its route byte with `oe_o` high, whatever the stored control bits are.
- R6: While `drive_en_i` is 0, every `oe_o` and `dout_o` bit is 0 in that same cycle, even for message slots.
- R7: A high `fp_i` forces the current bit position to 0 even in the middle of a frame. Output slot timing follows the new alignment from the next frame on.
- R8: The delay is exactly one frame for every source and destination pair. This includes a source in channel 31 that is switched into channel 0 of the next frame.
- R9: A connection write (`cfg_sel_i` 0 = route memory, 1 = control memory) changes the affected slot from the next frame on. Other slots are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high during bit 0 of channel 0 |
| din_i | input | 8 | Serial input bit of each stream |
| drive_en_i | input | 1 | Global output drive enable |
| msg_all_i | input | 1 | Global message-mode override |
| cfg_we_i | input | 1 | Connection memory write strobe |
| cfg_sel_i | input | 1 | 0 = route memory, 1 = control memory |
| cfg_stream_i | input | 3 | Output stream of the entry written |
| cfg_chan_i | input | 5 | Output channel of the entry written |
| cfg_data_i | input | 8 | Write data (control keeps bits 2 and 0) |
| dout_o | output | 8 | Serial output bit of each stream (0 when not driven) |
| oe_o | output | 8 | Per-stream output enable (low means high impedance) |

## Verification
A random connection map that mixes switched, message and disabled slots is checked slot by slot against a bench model over several frames. This separates the three per-slot modes and confirms that sources are decoded from the right fields. A reversed map sends stream 7 − o, channel 31 − k to stream o, channel k. It exercises the channel 31 into channel 0 crossing, which tells a true one-frame delay apart from a read of a half-written bank. A run with the global override, a run with the drive enable low, and a run with an early frame pulse followed by an all-message map separate the gating paths and the realignment from the data path. A single-entry rewrite shows that only the addressed slot changes.

// File: rtl/tsi_pkg.sv
// Package: shared types for the time-slot interchange switch.
// Assumes: control entries only need the message bit and the enable bit.
package tsi_pkg;

    // Selects which connection memory a write goes to.
    typedef enum logic {
        SEL_ROUTE = 1'b0,
        SEL_CTL   = 1'b1
    } cm_sel_e;

    // Per-slot control kept from a control-memory write.
    typedef struct packed {
        logic msg;   // send the route byte itself
        logic en;    // drive the slot
    } slot_ctl_t;

endpackage

// File: rtl/tsi_timing.sv
// Module: frame timing. Tracks the bit position inside a frame, realigns on
// the frame pulse, and chooses the data-memory banks for writing and
// prefetching.
// Assumes: NCHAN and BITS are powers of two; a frame pulse that comes early
// does not flip the bank (only a natural wrap flips it).
module tsi_timing #(
    parameter int NCHAN = 32,
    parameter int BITS  = 8,
    localparam int SLOTS = NCHAN * BITS,
    localparam int PW    = $clog2(SLOTS),
    localparam int BW    = $clog2(BITS),
    localparam int CW    = $clog2(NCHAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fp_i,
    output logic [PW-1:0] pos_o,
    output logic          slot_end_o,
    output logic [CW-1:0] cur_chan_o,
    output logic [CW-1:0] next_chan_o,
    output logic          wr_bank_o,
    output logic          rd_bank_o
);

    logic [PW-1:0] cnt_q;
    logic          bank_q;
    logic          frame_last;

    // Effective position: the frame pulse forces bit 0 of channel 0.
    always_comb begin
        pos_o = fp_i ? '0 : cnt_q;
    end

    assign frame_last  = (pos_o == PW'(SLOTS - 1));
    assign slot_end_o  = (pos_o[BW-1:0] == {BW{1'b1}});
    assign cur_chan_o  = pos_o[PW-1:BW];
    assign next_chan_o = cur_chan_o + CW'(1);
    assign wr_bank_o   = bank_q;
    // The prefetch for channel 0 happens in the last bit of a frame and must
    // already read the bank that is being completed.
    assign rd_bank_o   = frame_last ? bank_q : ~bank_q;

    // Advance the position and flip the bank at the natural end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bank_q <= 1'b0;
        end else begin
            cnt_q <= pos_o + PW'(1);
            if (frame_last) begin
                bank_q <= ~bank_q;
            end
        end
    end

endmodule

// File: rtl/tsi_rx.sv
// Module: serial receivers. One shift register per input stream; the full
// byte is presented in the last bit of each slot (MSB arrives first).
// Assumes: the caller writes the byte while slot_end is high.
module tsi_rx #(
    parameter int NSTREAM = 8,
    parameter int BITS    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSTREAM-1:0] din_i,
    output logic [BITS-1:0]    byte_o [NSTREAM]
);

    for (genvar s = 0; s < NSTREAM; s++) begin : g_lane
        logic [BITS-2:0] sh_q;

        // Shift in one serial bit per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else begin
                sh_q <= {sh_q[BITS-3:0], din_i[s]};
            end
        end

        assign byte_o[s] = {sh_q, din_i[s]};
    end

endmodule

// File: rtl/tsi_dmem.sv
// Module: frame-banked data memory. Two banks, each holding one byte per
// input stream and channel. It has one write port that stores all streams of
// a channel at once, and one read port per output stream. A read of the
// location being written in the same cycle returns the new byte.
// Assumes: contents need no reset; every location is written once a frame.
module tsi_dmem #(
    parameter int NSTREAM = 8,
    parameter int NCHAN   = 32,
    parameter int BITS    = 8,
    localparam int SW = $clog2(NSTREAM),
    localparam int CW = $clog2(NCHAN)
) (
    input  logic            clk,
    input  logic            we_i,
    input  logic            wbank_i,
    input  logic [CW-1:0]   wchan_i,
    input  logic [BITS-1:0] wdata_i   [NSTREAM],
    input  logic            rbank_i,
    input  logic [SW-1:0]   rstream_i [NSTREAM],
    input  logic [CW-1:0]   rchan_i   [NSTREAM],
    output logic [BITS-1:0] rdata_o   [NSTREAM]
);

    logic [BITS-1:0] mem_q [2][NSTREAM][NCHAN];

    // Store every stream's byte for the current channel.
    always_ff @(posedge clk) begin
        if (we_i) begin
            for (int s = 0; s < NSTREAM; s++) begin
                mem_q[wbank_i][s][wchan_i] <= wdata_i[s];
            end
        end
    end

    for (genvar o = 0; o < NSTREAM; o++) begin : g_rd
        logic hit;
        assign hit = we_i && (rbank_i == wbank_i) && (rchan_i[o] == wchan_i);

        // Read with forwarding of a same-cycle write.
        always_comb begin
            rdata_o[o] = hit ? wdata_i[rstream_i[o]]
                             : mem_q[rbank_i][rstream_i[o]][rchan_i[o]];
        end
    end

endmodule

// File: rtl/tsi_cmem.sv
// Module: connection memories. The route memory holds one byte per output
// stream and channel (source address or message byte). The control memory
// keeps bits 2 (message) and 0 (enable) of each write. It reads one entry per
// output stream for the channel being prefetched.
// Assumes: a write lands at the next edge; reset clears only the control
// memory, which is enough to keep every slot silent.
module tsi_cmem
    import tsi_pkg::*;
#(
    parameter int NSTREAM = 8,
    parameter int NCHAN   = 32,
    parameter int BITS    = 8,
    localparam int SW = $clog2(NSTREAM),
    localparam int CW = $clog2(NCHAN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  cm_sel_e         sel_i,
    input  logic [SW-1:0]   wstream_i,
    input  logic [CW-1:0]   wchan_i,
    input  logic [BITS-1:0] wdata_i,
    input  logic [CW-1:0]   rchan_i,
    output logic [BITS-1:0] route_o [NSTREAM],
    output slot_ctl_t       ctl_o   [NSTREAM]
);

    logic [BITS-1:0] route_q [NSTREAM][NCHAN];
    slot_ctl_t       ctl_q   [NSTREAM][NCHAN];

    // Route memory write.
    always_ff @(posedge clk) begin
        if (we_i && sel_i == SEL_ROUTE) begin
            route_q[wstream_i][wchan_i] <= wdata_i;
        end
    end

    // Control memory write; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTREAM; s++) begin
                for (int c = 0; c < NCHAN; c++) begin
                    ctl_q[s][c] <= '0;
                end
            end
        end else if (we_i && sel_i == SEL_CTL) begin
            ctl_q[wstream_i][wchan_i] <= '{msg: wdata_i[2], en: wdata_i[0]};
        end
    end

    for (genvar o = 0; o < NSTREAM; o++) begin : g_rd
        assign route_o[o] = route_q[o][rchan_i];
        assign ctl_o[o]   = ctl_q[o][rchan_i];
    end

endmodule

// File: rtl/tsi_tx.sv
// Module: serial transmitters. At a slot end each lane loads the byte and the
// enable for the next slot, then shifts the byte out MSB first. The global
// drive enable gates the outputs without a register in between.
// Assumes: load_i is high in the last bit of every slot.
module tsi_tx #(
    parameter int NSTREAM = 8,
    parameter int BITS    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [BITS-1:0]    byte_i [NSTREAM],
    input  logic [NSTREAM-1:0] en_i,
    input  logic               drive_en_i,
    output logic [NSTREAM-1:0] dout_o,
    output logic [NSTREAM-1:0] oe_o
);

    for (genvar o = 0; o < NSTREAM; o++) begin : g_lane
        logic [BITS-1:0] sh_q;
        logic            en_q;

        // Load at the slot boundary, otherwise shift toward the MSB.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '0;
                en_q <= 1'b0;
            end else if (load_i) begin
                sh_q <= byte_i[o];
                en_q <= en_i[o];
            end else begin
                sh_q <= {sh_q[BITS-2:0], 1'b0};
            end
        end

        assign oe_o[o]   = en_q & drive_en_i;
        assign dout_o[o] = sh_q[BITS-1] & oe_o[o];
    end

endmodule

// File: rtl/tsi_switch.sv
// Module: time-slot interchange switch, top level. It ties together frame
// timing, receivers, the banked data memory, the connection memories and the
// transmitters. It prefetches each slot one bit ahead of its boundary.
// Assumes: stream and channel address fields fill one route byte exactly
// (source stream in the upper bits, source channel in the lower bits).
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NSTREAM = 8,
    parameter int NCHAN   = 32,
    parameter int BITS    = 8,
    localparam int SW = $clog2(NSTREAM),
    localparam int CW = $clog2(NCHAN),
    localparam int BW = $clog2(BITS),
    localparam int PW = $clog2(NCHAN * BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fp_i,
    input  logic [NSTREAM-1:0] din_i,
    input  logic               drive_en_i,
    input  logic               msg_all_i,
    input  logic               cfg_we_i,
    input  logic               cfg_sel_i,
    input  logic [SW-1:0]      cfg_stream_i,
    input  logic [CW-1:0]      cfg_chan_i,
    input  logic [BITS-1:0]    cfg_data_i,
    output logic [NSTREAM-1:0] dout_o,
    output logic [NSTREAM-1:0] oe_o
);

    logic [PW-1:0]      pos;
    logic               slot_end;
    logic [CW-1:0]      cur_chan;
    logic [CW-1:0]      next_chan;
    logic               wr_bank;
    logic               rd_bank;
    logic [BITS-1:0]    rx_byte  [NSTREAM];
    logic [BITS-1:0]    route_rd [NSTREAM];
    slot_ctl_t          ctl_rd   [NSTREAM];
    logic [SW-1:0]      src_strm [NSTREAM];
    logic [CW-1:0]      src_chan [NSTREAM];
    logic [BITS-1:0]    dm_rd    [NSTREAM];
    logic [BITS-1:0]    tx_byte  [NSTREAM];
    logic [NSTREAM-1:0] slot_en;

    tsi_timing #(.NCHAN(NCHAN), .BITS(BITS)) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .fp_i        (fp_i),
        .pos_o       (pos),
        .slot_end_o  (slot_end),
        .cur_chan_o  (cur_chan),
        .next_chan_o (next_chan),
        .wr_bank_o   (wr_bank),
        .rd_bank_o   (rd_bank)
    );

    tsi_rx #(.NSTREAM(NSTREAM), .BITS(BITS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (din_i),
        .byte_o (rx_byte)
    );

    tsi_cmem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .BITS(BITS)) u_cmem (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .sel_i     (cm_sel_e'(cfg_sel_i)),
        .wstream_i (cfg_stream_i),
        .wchan_i   (cfg_chan_i),
        .wdata_i   (cfg_data_i),
        .rchan_i   (next_chan),
        .route_o   (route_rd),
        .ctl_o     (ctl_rd)
    );

    // Per output stream: decode the source and pick switched or message data.
    for (genvar o = 0; o < NSTREAM; o++) begin : g_sel
        logic msg_mode;
        assign src_strm[o] = route_rd[o][BITS-1 -: SW];
        assign src_chan[o] = route_rd[o][CW-1:0];
        assign msg_mode    = msg_all_i | ctl_rd[o].msg;
        assign slot_en[o]  = msg_all_i | ctl_rd[o].en;
        assign tx_byte[o]  = msg_mode ? route_rd[o] : dm_rd[o];
    end

    tsi_dmem #(.NSTREAM(NSTREAM), .NCHAN(NCHAN), .BITS(BITS)) u_dmem (
        .clk       (clk),
        .we_i      (slot_end),
        .wbank_i   (wr_bank),
        .wchan_i   (cur_chan),
        .wdata_i   (rx_byte),
        .rbank_i   (rd_bank),
        .rstream_i (src_strm),
        .rchan_i   (src_chan),
        .rdata_o   (dm_rd)
    );

    tsi_tx #(.NSTREAM(NSTREAM), .BITS(BITS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (slot_end),
        .byte_i     (tx_byte),
        .en_i       (slot_en),
        .drive_en_i (drive_en_i),
        .dout_o     (dout_o),
        .oe_o       (oe_o)
    );

endmodule

// File: rtl/tsi_switch_chk.sv
// Module: assertion checker for tsi_switch, attached by bind.
// Assumes: slot_bit is the bit index inside the current slot.
module tsi_switch_chk #(
    parameter int NSTREAM = 8,
    parameter int BW      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               drive_en_i,
    input logic               msg_all_i,
    input logic [NSTREAM-1:0] oe_o,
    input logic [NSTREAM-1:0] dout_o,
    input logic [BW-1:0]      slot_bit
);

    // R1: outputs are silent in the first cycle after reset.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (oe_o == '0 && dout_o == '0));

    // R6: drive enable low silences every stream in the same cycle.
    a_r6_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en_i |-> (oe_o == '0));

    // R4: a stream that is not enabled never shows a data one.
    a_r4_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_o & ~oe_o) == '0);

    // R5: with the override, every slot loaded at a boundary is driven.
    a_r5_msg_all_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(msg_all_i) && $past(slot_bit == {BW{1'b1}})
         && drive_en_i) |-> (oe_o == {NSTREAM{1'b1}}));

    // R2: enables change only at slot boundaries while drive enable holds.
    a_r2_slot_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_bit != '0 && $stable(drive_en_i)) |-> $stable(oe_o));

endmodule

bind tsi_switch tsi_switch_chk #(.NSTREAM(NSTREAM), .BW(BW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drive_en_i (drive_en_i),
    .msg_all_i  (msg_all_i),
    .oe_o       (oe_o),
    .dout_o     (dout_o),
    .slot_bit   (pos[BW-1:0])
);

// File: tb/tsi_switch_test.sv
// Directed bench for tsi_switch: one task per scenario, each checking its
// own frames against a model of the connection map and the received bytes.
module tsi_switch_test;
    localparam int NS = 8;
    localparam int NC = 32;
    localparam int FRAME = 256;

    logic          clk = 1'b0;
    logic          rst_n, fp, den, gmsg, cfg_we, cfg_sel;
    logic [NS-1:0] din;
    logic [2:0]    cfg_stream;
    logic [4:0]    cfg_chan;
    logic [7:0]    cfg_data;
    logic [NS-1:0] dout, oe;

    always #10 clk = ~clk;   // 50 MHz

    tsi_switch uut (
        .clk(clk), .rst_n(rst_n), .fp_i(fp), .din_i(din),
        .drive_en_i(den), .msg_all_i(gmsg), .cfg_we_i(cfg_we),
        .cfg_sel_i(cfg_sel), .cfg_stream_i(cfg_stream), .cfg_chan_i(cfg_chan),
        .cfg_data_i(cfg_data), .dout_o(dout), .oe_o(oe)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] rx_prev [NS][NC];
    logic [7:0] rx_cur  [NS][NC];
    logic [7:0] route_m [NS][NC];
    logic       msg_m   [NS][NC];
    logic       en_m    [NS][NC];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input bit sel, input int o, input int k,
                             input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_stream = 3'(o);
        cfg_chan = 5'(k); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_cfg();
        for (int o = 0; o < NS; o++) begin
            for (int k = 0; k < NC; k++) begin
                cfg_write(1'b0, o, k, route_m[o][k]);
                cfg_write(1'b1, o, k, {5'b0, msg_m[o][k], 1'b0, en_m[o][k]});
            end
        end
    endtask

    // Drives one frame (or its first ncyc bits) and, if asked, checks every
    // output slot. base "R2" picks the tag per slot mode, others force it.
    task automatic run_frame(input bit chk, input string base, input int ncyc);
        logic [7:0] got    [NS][NC];
        logic       oe_hi  [NS][NC];
        logic       oe_lo  [NS][NC];
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++) begin
                rx_cur[s][c] = 8'($urandom);
                oe_hi[s][c] = 1'b0;
                oe_lo[s][c] = 1'b0;
                got[s][c] = '0;
            end
        for (int p = 0; p < ncyc; p++) begin
            @(negedge clk);
            fp = (p == 0);
            for (int s = 0; s < NS; s++) din[s] = rx_cur[s][p / 8][7 - (p % 8)];
            #1;
            for (int o = 0; o < NS; o++) begin
                got[o][p / 8] = {got[o][p / 8][6:0], dout[o]};
                if (oe[o]) oe_hi[o][p / 8] = 1'b1;
                else       oe_lo[o][p / 8] = 1'b1;
            end
        end
        fp = 1'b0;
        if (chk) begin
            for (int o = 0; o < NS; o++) begin
                for (int k = 0; k < NC; k++) begin
                    logic       eoe, emsg, ok;
                    logic [7:0] eb;
                    string      tag;
                    eoe  = (gmsg | en_m[o][k]) & den;
                    emsg = gmsg | msg_m[o][k];
                    if (!eoe)      eb = 8'h00;
                    else if (emsg) eb = route_m[o][k];
                    else           eb = rx_prev[route_m[o][k][7:5]][route_m[o][k][4:0]];
                    if (base != "R2")       tag = base;
                    else if (gmsg)          tag = "R5";
                    else if (!den)          tag = "R6";
                    else if (!en_m[o][k])   tag = "R4";
                    else if (msg_m[o][k])   tag = "R3";
                    else                    tag = "R2";
                    ok = (got[o][k] == eb) && (eoe ? !oe_lo[o][k] : !oe_hi[o][k]);
                    check(ok, tag, $sformatf("out %0d ch %0d byte/oe", o, k),
                          {got[o][k], 3'b0, oe_hi[o][k], 3'b0, oe_lo[o][k]},
                          {eb, 3'b0, eoe, 3'b0, !eoe});
                end
            end
        end
        if (ncyc == FRAME) rx_prev = rx_cur;
    endtask

    task automatic t_reset();   // R1
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(oe == '0 && dout == '0, "R1", "oe/dout in reset", {oe, dout}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(oe == '0 && dout == '0, "R1", "oe/dout after reset", {oe, dout}, 0);
        run_frame(1'b1, "R1", FRAME);   // all control entries clear: silent
    endtask

    task automatic t_switched();   // R2, R3, R4
        for (int o = 0; o < NS; o++)
            for (int k = 0; k < NC; k++) begin
                int r;
                r = int'($urandom % 10);
                route_m[o][k] = 8'($urandom);
                msg_m[o][k]   = (r < 2);
                en_m[o][k]    = !(r == 2 || r == 3);
            end
        load_cfg();
        run_frame(1'b0, "R2", FRAME);
        repeat (3) run_frame(1'b1, "R2", FRAME);
    endtask

    task automatic t_reverse();   // R8
        for (int o = 0; o < NS; o++)
            for (int k = 0; k < NC; k++) begin
                route_m[o][k] = {3'(NS - 1 - o), 5'(NC - 1 - k)};
                msg_m[o][k] = 1'b0;
                en_m[o][k]  = 1'b1;
            end
        load_cfg();
        run_frame(1'b0, "R8", FRAME);
        repeat (2) run_frame(1'b1, "R8", FRAME);
    endtask

    task automatic t_msg_all();   // R5
        for (int o = 0; o < NS; o++)
            for (int k = 0; k < NC; k++) begin
                route_m[o][k] = 8'($urandom);
                msg_m[o][k]   = 1'($urandom);
                en_m[o][k]    = 1'($urandom);
            end
        load_cfg();
        gmsg = 1'b1;
        run_frame(1'b0, "R5", FRAME);
        run_frame(1'b1, "R5", FRAME);
        gmsg = 1'b0;
    endtask

    task automatic t_drive_off();   // R6
        den = 1'b0;
        run_frame(1'b1, "R6", FRAME);
        den = 1'b1;
        run_frame(1'b0, "R6", FRAME);
        run_frame(1'b1, "R2", FRAME);
    endtask

    task automatic t_realign();   // R7
        for (int o = 0; o < NS; o++)
            for (int k = 0; k < NC; k++) begin
                route_m[o][k] = {3'(o), 5'(k)} ^ 8'h5A;
                msg_m[o][k] = 1'b1;
                en_m[o][k]  = 1'b1;
            end
        load_cfg();
        run_frame(1'b0, "R7", FRAME);
        run_frame(1'b0, "R7", 100);
        run_frame(1'b0, "R7", FRAME);
        run_frame(1'b1, "R7", FRAME);
    endtask

    task automatic t_update();   // R9
        run_frame(1'b0, "R9", FRAME);
        cfg_write(1'b0, 3, 10, 8'hA5);
        route_m[3][10] = 8'hA5;
        cfg_write(1'b0, 5, 20, {3'd2, 5'd7});
        cfg_write(1'b1, 5, 20, 8'h01);
        route_m[5][20] = {3'd2, 5'd7};
        msg_m[5][20] = 1'b0;
        run_frame(1'b0, "R9", FRAME);
        repeat (2) run_frame(1'b1, "R9", FRAME);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        fp = 1'b0; din = '0; den = 1'b1; gmsg = 1'b0; cfg_we = 1'b0;
        cfg_sel = 1'b0; cfg_stream = '0; cfg_chan = '0; cfg_data = '0;
        for (int o = 0; o < NS; o++)
            for (int k = 0; k < NC; k++) begin
                route_m[o][k] = '0; msg_m[o][k] = 1'b0; en_m[o][k] = 1'b0;
                rx_prev[o][k] = '0;
            end
        t_reset();
        t_switched();
        t_reverse();
        t_msg_all();
        t_drive_off();
        t_realign();
        t_update();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule